// File: doc/BRIEF.md
# I2C Serial Memory Target

This block is a target device on a two-wire I2C bus that fronts a 512-byte memory array held in flip-flops. A host selects it with a fixed 7-bit device address. The least significant bit of the address byte selects a write (0) or a read (1). In a write, the host then sends a two-byte word address followed by data bytes. These bytes are collected in a 16-byte page buffer, and the array is updated only after a timed busy window that follows the STOP. During that window the target refuses to acknowledge its own address, so the host can poll for completion.

Reads use one internal address pointer. A current-address read starts at that pointer. A random read sets the pointer with a write that carries no data, then a repeated START and a read address byte. A sequential read continues for as long as the host acknowledges. The bus pins arrive as separate input, output and enable signals. The block drives the line low by raising `sda_oe` and never drives it high.

Top module: `i2c_mem_target`

## Requirements
- R1: An address byte of 0xAE (write) or 0xAF (read) is acknowledged by pulling SDA low during the ninth clock. Any other address byte is not acknowledged, and SDA stays released for the rest of that transfer.
- R2: In a write, the two bytes after the address byte form the word address, high byte first. Only its low 9 bits are kept. Each accepted byte is acknowledged.
- R3: Data bytes in a write land within one 16-byte page, chosen by address bits [8:4]. After page offset 15 the next byte goes to offset 0 of the same page.
- R4: A STOP that ends a write which carried at least one data byte starts a busy window of BUSY_CYCLES system clocks. The buffered bytes appear in the array when the window ends.
- R5: During the busy window the address byte is not acknowledged, and any address or data that follows is ignored. After the window ends the address byte is acknowledged again.
- R6: The pointer holds the last accessed address plus one, so a current-address read returns the byte after the last one written or read.
- R7: After reset the pointer is 0, every array byte reads 0x00, and SDA is released.
- R8: A write that carries a word address and no data, followed by a repeated START and 0xAF, reads from that word address.
- R9: In a read, a host ACK on the ninth clock makes the next byte follow at address plus one, wrapping from 511 to 0. A host NACK ends the read and releases SDA.
- R10: The SDA drive changes only while SCL is low. Data bytes are shifted out most significant bit first.
- R11: A write that ends in STOP without any data byte starts no busy window, so the next address byte is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bus lines are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_o | output | 1 | Level driven onto SDA when enabled, always 0 |
| sda_oe | output | 1 | High to pull SDA low |

## Verification
On every cycle, the assertions check that the SDA enable only moves after a cycle with SCL low. They also check that each byte loaded for transmission advances the pointer by exactly one, that no byte enters the page buffer while the window is running, and that the busy window opens only on a STOP with buffered data and clears the buffer when it closes. Page wraparound, wraparound at the end of the array, the NACK during polling and the discarding of writes sent in the busy window only show up in the array contents. The bench's transactions read those contents back over the bus, and that is the only way to expose them.

// File: rtl/i2c_mem_pkg.sv
`timescale 1ns/1ps
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_HACK
  } bus_state_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_AHI,
    K_ALO,
    K_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2c_mem_sync.sv
`timescale 1ns/1ps
module i2c_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_mem_ctrl.sv
`timescale 1ns/1ps
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
#(
  parameter int         AW       = 9,
  parameter int         PW       = 4,
  parameter logic [6:0] DEV_ADDR = 7'h57
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          busy,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          commit_req,
  output logic          sda_oe
);
  localparam logic [AW-1:0] ONE_A = 1;
  localparam logic [PW-1:0] ONE_P = 1;

  bus_state_t     st, st_n;
  byte_kind_t     kind, kind_n;
  logic [3:0]     cnt, cnt_n;
  logic [7:0]     sh, sh_n;
  logic [AW-1:0]  ptr, ptr_n;
  logic [AW-9:0]  ahi, ahi_n;
  logic           ack_q, ack_n;
  logic           is_rd, rd_n;
  logic           oe, oe_n;
  logic           load_rd, take;

  assign rd_addr = ptr;
  assign wr_addr = ptr;
  assign wr_data = sh;
  assign sda_oe  = oe;

  always_comb begin
    st_n = st; kind_n = kind; cnt_n = cnt; sh_n = sh; ptr_n = ptr;
    ahi_n = ahi; ack_n = ack_q; rd_n = is_rd; oe_n = oe;
    wr_en = 1'b0; commit_req = 1'b0; load_rd = 1'b0; take = 1'b0;
    if (start_evt) begin
      st_n = ST_RX; kind_n = K_DEV; cnt_n = '0; oe_n = 1'b0;
    end else if (stop_evt) begin
      st_n = ST_IDLE; oe_n = 1'b0; commit_req = 1'b1;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            sh_n  = {sh[6:0], sda_s};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            case (kind)
              K_DEV: begin
                take = (sh[7:1] == DEV_ADDR) && !busy;
                rd_n = sh[0];
              end
              K_AHI: begin
                take  = 1'b1;
                ahi_n = sh[AW-9:0];
              end
              K_ALO: begin
                take  = 1'b1;
                ptr_n = {ahi, sh};
              end
              default: begin
                take  = 1'b1;
                wr_en = 1'b1;
                ptr_n = {ptr[AW-1:PW], ptr[PW-1:0] + ONE_P};
              end
            endcase
            st_n = ST_ACK; oe_n = take; ack_n = take; cnt_n = '0;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_q) begin
              st_n = ST_IDLE; oe_n = 1'b0;
            end else if (kind == K_DEV && is_rd) begin
              load_rd = 1'b1;
            end else begin
              st_n = ST_RX; oe_n = 1'b0; cnt_n = '0;
              case (kind)
                K_DEV:   kind_n = K_AHI;
                K_AHI:   kind_n = K_ALO;
                default: kind_n = K_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              st_n = ST_HACK; oe_n = 1'b0;
            end else begin
              sh_n = {sh[6:0], 1'b0};
              oe_n = ~sh[6];
            end
          end
        end
        ST_HACK: begin
          if (scl_rise) begin
            ack_n = ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) load_rd = 1'b1;
            else st_n = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
    if (load_rd) begin
      st_n  = ST_TX;
      sh_n  = rd_data;
      ptr_n = ptr + ONE_A;
      oe_n  = ~rd_data[7];
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      kind  <= K_DEV;
      cnt   <= '0;
      sh    <= '0;
      ptr   <= '0;
      ahi   <= '0;
      ack_q <= 1'b0;
      is_rd <= 1'b0;
      oe    <= 1'b0;
    end else begin
      st    <= st_n;
      kind  <= kind_n;
      cnt   <= cnt_n;
      sh    <= sh_n;
      ptr   <= ptr_n;
      ahi   <= ahi_n;
      ack_q <= ack_n;
      is_rd <= rd_n;
      oe    <= oe_n;
    end
  end

  // R10: the drive may only move after a cycle in which SCL was seen low
  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R9: each byte fetched for sending moves the pointer on by one
  assert_rd_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_rd |=> (ptr == $past(ptr) + ONE_A));

  // R3: a buffered write never leaves the current page
  assert_wr_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr[AW-1:PW] == $past(wr_addr[AW-1:PW])));
endmodule

// File: rtl/i2c_mem_array.sv
`timescale 1ns/1ps
module i2c_mem_array #(
  parameter int DEPTH       = 512,
  parameter int PAGE        = 16,
  parameter int BUSY_CYCLES = 250000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [7:0]               wr_data,
  input  logic                     commit_req,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [7:0]               rd_data,
  output logic                     busy
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [BW-1:0] ONE_B  = 1;
  localparam logic [BW-1:0] LOAD_B = BW'(BUSY_CYCLES);

  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [PAGE];
  logic [PAGE-1:0]  vld, vld_n;
  logic [AW-PW-1:0] page;
  logic [BW-1:0]    bcnt, bcnt_n;
  logic             busy_n, start_busy, done;

  assign rd_data = mem[rd_addr];

  always_comb begin
    start_busy = commit_req && !busy && (|vld);
    done       = busy && (bcnt == ONE_B);
    bcnt_n     = bcnt;
    if (start_busy) bcnt_n = LOAD_B;
    else if (busy)  bcnt_n = bcnt - ONE_B;
    busy_n = start_busy || (busy && !done);
    vld_n  = vld;
    if (done) vld_n = '0;
    else if (wr_en) vld_n[wr_addr[PW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      bcnt <= '0;
      vld  <= '0;
      page <= '0;
    end else begin
      busy <= busy_n;
      bcnt <= bcnt_n;
      vld  <= vld_n;
      if (wr_en) page <= wr_addr[AW-1:PW];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) pbuf[wr_addr[PW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (done) begin
      for (int i = 0; i < PAGE; i++) begin
        if (vld[i]) mem[{page, PW'(i)}] <= pbuf[i];
      end
    end
  end

  // R5: nothing enters the page buffer while the window runs
  assert_no_write_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_en);

  // R4: the window opens only on a STOP with buffered data
  assert_busy_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(commit_req) && (|$past(vld))));

  // R4: closing the window empties the buffer
  assert_busy_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (vld == '0));
endmodule

// File: rtl/i2c_mem_target.sv
`timescale 1ns/1ps
module i2c_mem_target #(
  parameter int         MEM_BYTES   = 512,
  parameter int         PAGE_BYTES  = 16,
  parameter int         BUSY_CYCLES = 250000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h57
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_oe
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [1:0]    rst_sh;
  logic          rst_int;
  logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic          busy, wr_en, commit_req;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_int = rst_sh[1];
  assign sda_o   = 1'b0;

  i2c_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_mem_ctrl #(.AW(AW), .PW(PW), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_int), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_req(commit_req), .sda_oe(sda_oe)
  );

  i2c_mem_array #(.DEPTH(MEM_BYTES), .PAGE(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_array (
    .clk(clk), .rst_n(rst_int), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_req(commit_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );
endmodule

// File: tb/i2c_mem_target_bench.sv
`timescale 1ns/1ps
module i2c_mem_target_bench;
  localparam int BUSY = 3000;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_bus, sda_o, sda_oe;

  assign sda_bus = host_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_mem_target #(.BUSY_CYCLES(BUSY)) u_i2c_mem_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe(sda_oe)
  );

  int total = 0;
  int bad = 0;
  string tag_q[$];
  int val_q[$];
  int obs_val;
  event obs_ev;
  logic [7:0] mdl_mem [512];
  int mdl_ptr = 0;

  task automatic expect_item(input string t, input int v);
    tag_q.push_back(t);
    val_q.push_back(v);
  endtask

  task automatic observe(input int v);
    obs_val = v;
    -> obs_ev;
  endtask

  // monitor: pops the oldest expectation for each observed result
  initial begin
    forever begin
      @(obs_ev);
      total++;
      if (tag_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard-empty act=%0h exp=none", obs_val);
      end else begin
        string t;
        int e;
        t = tag_q.pop_front();
        e = val_q.pop_front();
        if (obs_val != e) begin
          bad++;
          $display("FAIL %s act=%0h exp=%0h", t, obs_val, e);
        end
      end
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", t, act, exp);
    end
  endtask

  task automatic q_wait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    host_sda = b; q_wait();
    scl = 1'b1;   q_wait();
    s = sda_bus;  q_wait();
    scl = 1'b0;   q_wait();
  endtask

  task automatic bus_start();
    host_sda = 1'b1; q_wait();
    scl = 1'b1;      q_wait();
    host_sda = 1'b0; q_wait();
    scl = 1'b0;      q_wait();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; q_wait();
    scl = 1'b1;      q_wait();
    host_sda = 1'b1; q_wait();
  endtask

  task automatic send_byte(input logic [7:0] b, output int ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ack = s ? 0 : 1;
  endtask

  task automatic recv_byte(input logic host_ack, output int b);
    logic s;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      v[i] = s;
    end
    bit_xfer(~host_ack, s);
    b = int'(v);
  endtask

  task automatic sent_exp(input string t, input logic [7:0] b, input int exp_ack);
    int a;
    expect_item(t, exp_ack);
    send_byte(b, a);
    observe(a);
  endtask

  // R2, R3: word address then data; the model keeps 9 bits and wraps in the page
  task automatic do_write(input int addr, input int n, input int seed);
    bus_start();
    sent_exp("R1", 8'hAE, 1);
    sent_exp("R2", addr[15:8], 1);
    sent_exp("R2", addr[7:0], 1);
    mdl_ptr = addr & 511;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'((seed + i) & 255);
      sent_exp("R2", d, 1);
      mdl_mem[mdl_ptr] = d;
      mdl_ptr = (mdl_ptr & 9'h1F0) | ((mdl_ptr + 1) & 15);
    end
    bus_stop();
  endtask

  task automatic set_addr(input int addr, input bit with_stop);
    bus_start();
    sent_exp("R8", 8'hAE, 1);
    sent_exp("R8", addr[15:8], 1);
    sent_exp("R8", addr[7:0], 1);
    mdl_ptr = addr & 511;
    if (with_stop) bus_stop();
  endtask

  task automatic cur_read(input int n, input string t);
    int b;
    bus_start();
    sent_exp("R1", 8'hAF, 1);
    for (int i = 0; i < n; i++) begin
      expect_item(t, int'(mdl_mem[mdl_ptr]));
      mdl_ptr = (mdl_ptr + 1) & 511;
      recv_byte(i < n - 1, b);
      observe(b);
    end
    bus_stop();
    chk("R9", int'(sda_oe), 0);
  endtask

  task automatic poll(input int exp_ack, input string t);
    bus_start();
    sent_exp(t, 8'hAE, exp_ack);
    bus_stop();
  endtask

  task automatic wait_busy();
    repeat (BUSY + 200) @(negedge clk);
  endtask

  initial begin
    repeat (BUSY * 60) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a;
    for (int i = 0; i < 512; i++) mdl_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7: released bus, pointer at 0, zeroed array
    chk("R7", int'(sda_oe), 0);
    cur_read(1, "R7");
    cur_read(1, "R6");

    // R1: foreign address gets no ACK
    bus_start();
    sent_exp("R1", 8'hA0, 0);
    sent_exp("R1", 8'h00, 0);
    bus_stop();

    // R3: 12 bytes from page offset 10 wrap to offsets 0..5
    do_write(16'h001A, 12, 8'hD0);
    poll(0, "R5");
    wait_busy();
    poll(1, "R5");
    poll(1, "R11");
    set_addr(16'h0010, 1'b1);
    cur_read(16, "R3");
    set_addr(16'h0019, 1'b0);
    cur_read(1, "R8");
    cur_read(2, "R6");

    // R4: window still open late, closed after its length
    do_write(16'h0000, 1, 8'h3C);
    repeat (BUSY - 800) @(negedge clk);
    poll(0, "R4");
    wait_busy();
    poll(1, "R4");

    // R2: upper address bits dropped; R9: sequential wrap 511 -> 0
    do_write(16'hFFFF, 2, 8'h5A);
    wait_busy();
    set_addr(16'h01FE, 1'b0);
    cur_read(3, "R9");
    set_addr(16'h01F0, 1'b0);
    cur_read(1, "R10");

    // R5: a write sent during the window is dropped
    do_write(16'h0040, 1, 8'h77);
    bus_start();
    sent_exp("R5", 8'hAE, 0);
    send_byte(8'h00, a);
    send_byte(8'h40, a);
    send_byte(8'h99, a);
    bus_stop();
    wait_busy();
    set_addr(16'h0040, 1'b0);
    cur_read(2, "R5");

    repeat (20) @(negedge clk);
    chk("R9", tag_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule